// File: doc/BRIEF.md
# Predicated Three-Way Interleaving Store Sequencer

This block turns three vector operands into a stream of single-byte memory writes. Byte e of each operand is placed side by side, so memory receives a run of three-byte records. Record e holds byte e of operand A, then byte e of operand B, then byte e of operand C. One predicate bit per element decides whether that record is written. The write address steps forward for every slot, including slots that are skipped.

A caller presents the operands, the predicate, a 64-bit base, a 64-bit index and the two register-field codes, then pulses `start`. While `busy` is high the block offers one byte at a time on a valid/ready request port. It pulses `done` when the sequence ends. A fault raises `done` together with `undef` or `align_fault`, and in that case no write is issued.

The index field code 31 is illegal. The base field code 31 selects the stack pointer, which must be 16-byte aligned whenever the alignment check applies.

Top module: `tri_interleave_store`

## Requirements
- R1: Element e gives three consecutive bytes. Operand A byte e goes to address S+3e, operand B byte e to S+3e+1 and operand C byte e to S+3e+2. Byte e is bits [8e+7:8e] of each operand, and S is the start address.
- R2: S equals base plus index, modulo 2^64. Address wraps past all-ones back to zero.
- R3: Requests come out in element-major order: element 0 slots A, B, C, then element 1, and so on up to element VL/8-1.
- R4: A record whose predicate bit `pred[e]` is 0 produces no write. The addresses of later records are unaffected, and each skipped slot takes one cycle.
- R5: When `idx_field` is 31 at start, `done` and `undef` pulse together in the cycle after start, and no write is requested.
- R6: When `base_field` is 31, at least one predicate bit is set and `base[3:0]` is nonzero, `done` and `align_fault` pulse together in the cycle after start, and no write is requested. `undef` takes priority over this fault.
- R7: When `base_field` is 31 and no predicate bit is set, the alignment check applies only if `chk_sp_idle` is 1. Otherwise the sequence runs through all slots and issues no write.
- R8: A request with `wr_valid` high and `wr_ready` low keeps the same address and data in the next cycle.
- R9: `busy` is high for one cycle per slot while `wr_ready` stays 1, which is 3*VL/8 cycles. `done` pulses once, in the cycle after the final slot. A `start` pulse while busy is ignored.
- R10: After reset, `busy`, `done`, `undef`, `align_fault` and `wr_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| base | input | 64 | Base address value |
| index | input | 64 | Index value in bytes |
| base_field | input | 5 | Base register code; 31 means stack pointer |
| idx_field | input | 5 | Index register code; 31 is illegal |
| chk_sp_idle | input | 1 | Perform the stack-pointer check even when no element is active |
| vec_a | input | VL | First operand |
| vec_b | input | VL | Second operand |
| vec_c | input | VL | Third operand |
| pred | input | VL/8 | Per-element predicate |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| undef | output | 1 | Illegal index field, valid with done |
| align_fault | output | 1 | Stack-pointer misalignment, valid with done |
| wr_valid | output | 1 | Byte write request valid |
| wr_ready | input | 1 | Byte write request accepted |
| wr_addr | output | 64 | Byte write address |
| wr_data | output | 8 | Byte write data |

## Verification
The hardest situation to reach from the ports is a stalled request that sits beside skipped records and an address that is about to wrap. All three must hold at once to show that stalls freeze the address while skips still advance it. The stimulus places the start address a few bytes below 2^64 and uses a sparse random predicate. It drops `wr_ready` at random, so that stalls fall on the wrap point and on both sides of inactive records. A separate case pulses `start` in the middle of a run with a different base, to show that the running sequence is left untouched.

// File: rtl/tri_interleave_store.sv
module tri_interleave_store #(
  parameter int VL = 128,
  parameter int AW = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   base,
  input  logic [AW-1:0]   index,
  input  logic [4:0]      base_field,
  input  logic [4:0]      idx_field,
  input  logic            chk_sp_idle,
  input  logic [VL-1:0]   vec_a,
  input  logic [VL-1:0]   vec_b,
  input  logic [VL-1:0]   vec_c,
  input  logic [VL/8-1:0] pred,
  output logic            busy,
  output logic            done,
  output logic            undef,
  output logic            align_fault,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [AW-1:0]   wr_addr,
  output logic [7:0]      wr_data
);
  localparam int NE = VL / 8;
  localparam int EW = $clog2(NE);

  logic [VL-1:0] a_q, b_q, c_q;
  logic [NE-1:0] p_q;
  logic [EW-1:0] elem;
  logic [1:0]    slot;
  logic [AW-1:0] addr_q;
  logic          busy_q, done_q, undef_q, fault_q;

  wire any_act  = |pred;
  wire sp_check = (base_field == 5'd31) && (any_act || chk_sp_idle);
  wire misalign = base[3:0] != 4'd0;
  wire bad_idx  = idx_field == 5'd31;
  wire accept   = start && !busy_q;
  wire cur_act  = p_q[elem];
  wire step     = busy_q && (!cur_act || wr_ready);
  wire last     = (elem == EW'(NE - 1)) && (slot == 2'd2);

  logic [7:0] byte_sel;
  always_comb begin
    case (slot)
      2'd0:    byte_sel = a_q[elem*8 +: 8];
      2'd1:    byte_sel = b_q[elem*8 +: 8];
      default: byte_sel = c_q[elem*8 +: 8];
    endcase
  end

  assign busy        = busy_q;
  assign done        = done_q;
  assign undef       = undef_q;
  assign align_fault = fault_q;
  assign wr_valid    = busy_q && cur_act;
  assign wr_addr     = addr_q;
  assign wr_data     = byte_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      undef_q <= 1'b0;
      fault_q <= 1'b0;
      elem    <= '0;
      slot    <= 2'd0;
      addr_q  <= '0;
      a_q     <= '0;
      b_q     <= '0;
      c_q     <= '0;
      p_q     <= '0;
    end else begin
      done_q  <= 1'b0;
      undef_q <= 1'b0;
      fault_q <= 1'b0;
      if (accept) begin
        if (bad_idx) begin
          done_q  <= 1'b1;
          undef_q <= 1'b1;
        end else if (sp_check && misalign) begin
          done_q  <= 1'b1;
          fault_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          elem   <= '0;
          slot   <= 2'd0;
          addr_q <= base + index;
          a_q    <= vec_a;
          b_q    <= vec_b;
          c_q    <= vec_c;
          p_q    <= pred;
        end
      end else if (step) begin
        addr_q <= addr_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else if (slot == 2'd2) begin
          slot <= 2'd0;
          elem <= elem + 1'b1;
        end else begin
          slot <= slot + 1'b1;
        end
      end
    end
  end
endmodule

module tri_interleave_store_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          undef,
  input logic          align_fault,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data
);
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !undef && !align_fault |-> !busy && $past(busy));
  // R5
  undef_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> done && !align_fault && !busy);
  // R6
  fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> done && !busy);
  // R10
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid);
endmodule

bind tri_interleave_store tri_interleave_store_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .undef(undef),
  .align_fault(align_fault), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/tri_interleave_store_test.sv
module tri_interleave_store_test;
  localparam int VL = 128;
  localparam int NE = VL / 8;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [63:0] base = 0, index = 0;
  logic [4:0] base_field = 0, idx_field = 0;
  logic chk_sp_idle = 0;
  logic [VL-1:0] vec_a = 0, vec_b = 0, vec_c = 0;
  logic [NE-1:0] pred = 0;
  logic busy, done, undef, align_fault, wr_valid, wr_ready;
  logic [63:0] wr_addr;
  logic [7:0] wr_data;

  int tot = 0, bad = 0;
  logic [71:0] expq[$];

  always #2.5 clk = ~clk;

  tri_interleave_store #(.VL(VL)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .index(index),
    .base_field(base_field), .idx_field(idx_field), .chk_sp_idle(chk_sp_idle),
    .vec_a(vec_a), .vec_b(vec_b), .vec_c(vec_c), .pred(pred),
    .busy(busy), .done(done), .undef(undef), .align_fault(align_fault),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(input bit ok, input string req, input logic [71:0] act, exp);
    tot++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [VL-1:0] rvec();
    logic [VL-1:0] v;
    for (int i = 0; i < VL / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  // rmode: 0 always ready, 1 random ready
  task automatic run_op(input logic [63:0] b, ix, input logic [4:0] rn, rm,
                        input logic chk, input logic [NE-1:0] p, input int rmode,
                        input bit poke, input string tag);
    logic [VL-1:0] a0, a1, a2;
    logic [63:0] s;
    bit eu, ef, fin, stall;
    logic [71:0] prev;
    int bcnt;
    a0 = rvec(); a1 = rvec(); a2 = rvec();
    eu = (rm == 5'd31);
    ef = !eu && rn == 5'd31 && ((|p) || chk) && b[3:0] != 4'd0;
    expq.delete();
    s = b + ix;
    if (!eu && !ef)
      for (int e = 0; e < NE; e++)
        if (p[e]) begin
          expq.push_back({s + 64'(3*e),     a0[e*8 +: 8]});
          expq.push_back({s + 64'(3*e + 1), a1[e*8 +: 8]});
          expq.push_back({s + 64'(3*e + 2), a2[e*8 +: 8]});
        end
    @(negedge clk);
    base = b; index = ix; base_field = rn; idx_field = rm; chk_sp_idle = chk;
    vec_a = a0; vec_b = a1; vec_c = a2; pred = p; start = 1;
    @(negedge clk);
    start = 0;
    fin = 0; stall = 0; bcnt = 0; prev = '0;
    for (int cyc = 0; cyc < 2000 && !fin; cyc++) begin
      if (cyc > 0) @(negedge clk);
      start = 0;
      if (poke && cyc == 6) begin
        start = 1; base = b + 64'd1000; pred = ~p; vec_a = ~a0;
      end
      wr_ready = (rmode == 0) ? 1'b1 : 1'($urandom % 3 != 0);
      #1;
      if (stall)
        check(wr_valid && {wr_addr, wr_data} == prev, {tag, " R8 hold"},
              {wr_addr, wr_data}, prev);
      if (wr_valid) begin
        if (expq.size() == 0)
          check(0, {tag, " R4 unexpected write"}, {wr_addr, wr_data}, '0);
        else
          check({wr_addr, wr_data} == expq[0], {tag, " R1 R3 write"},
                {wr_addr, wr_data}, expq[0]);
        if (wr_ready && expq.size() > 0) void'(expq.pop_front());
      end
      stall = wr_valid && !wr_ready;
      prev = {wr_addr, wr_data};
      if (busy) bcnt++;
      if (done) begin
        fin = 1;
        check(undef == eu, {tag, " R5 undef"}, 72'(undef), 72'(eu));
        check(align_fault == ef, {tag, " R6 R7 fault"}, 72'(align_fault), 72'(ef));
        check(expq.size() == 0, {tag, " R4 writes left"}, 72'(expq.size()), 72'd0);
        if (rmode == 0 && !eu && !ef)
          check(bcnt == 3 * NE, {tag, " R9 busy cycles"}, 72'(bcnt), 72'(3 * NE));
        if (eu || ef)
          check(bcnt == 0, {tag, " R5 R6 no run"}, 72'(bcnt), 72'd0);
      end
    end
    check(fin, {tag, " R9 done seen"}, 72'(fin), 72'd1);
    start = 0;
    wr_ready = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!busy && !done && !wr_valid, {tag, " R9 quiet after done"},
            {69'd0, busy, done, wr_valid}, 72'd0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    check(0, "watchdog", 72'd0, 72'd1);
    $display("%0d/%0d checks passed", tot - bad, tot);
    $finish;
  end

  initial begin
    wr_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10
    check(!busy && !done && !undef && !align_fault && !wr_valid, "R10 reset",
          {67'd0, busy, done, undef, align_fault, wr_valid}, 72'd0);
    run_op(64'h1000, 64'h20, 5'd3, 5'd4, 0, '1, 0, 0, "full");
    run_op(64'h8000_0000, 64'h7, 5'd1, 5'd2, 0, NE'($urandom), 1, 0, "sparse");
    // R2 wrap across 2^64
    run_op(64'hFFFF_FFFF_FFFF_FFF0, 64'h9, 5'd0, 5'd5, 0, 16'hA5C3, 1, 0, "wrap R2");
    run_op(64'h40, 64'h0, 5'd2, 5'd31, 0, '1, 0, 0, "illegal idx R5");
    run_op(64'h48, 64'h0, 5'd31, 5'd31, 0, '1, 0, 0, "undef prio R6");
    run_op(64'h44, 64'h10, 5'd31, 5'd3, 0, 16'h0100, 0, 0, "sp misaligned R6");
    run_op(64'h40, 64'h13, 5'd31, 5'd3, 0, 16'h8001, 1, 0, "sp aligned R6");
    run_op(64'h44, 64'h10, 5'd31, 5'd3, 0, '0, 0, 0, "sp idle nochk R7");
    run_op(64'h44, 64'h10, 5'd31, 5'd3, 1, '0, 0, 0, "sp idle chk R7");
    run_op(64'h44, 64'h10, 5'd7, 5'd3, 0, '0, 0, 0, "none active R4");
    run_op(64'h2000, 64'h3, 5'd6, 5'd8, 0, 16'h3FFC, 0, 1, "start busy R9");
    for (int i = 0; i < 4; i++)
      run_op({$urandom, $urandom}, {$urandom, $urandom}, 5'd9, 5'd10, 0,
             NE'($urandom), 1, 0, "random");
    $display("%0d/%0d checks passed", tot - bad, tot);
    $finish;
  end
endmodule